// File: doc/BRIEF.md
# Timer-Scheduled Asynchronous Serial Receiver

This block receives 8-bit asynchronous serial characters. It has no baud counter and does no oversampling. Sample instants come from a free-running timer that other logic shares, and from a single channel that switches between capture and compare.

While the channel is idle it watches for the falling edge of a start bit. When that edge arrives, it captures the timer value. It then aims a compare target at the middle of the first data bit and changes to compare mode. On every match it samples the synchronized line and shifts the bit in. It then moves the target forward by one bit period.

After the eighth bit the byte is presented and a one-cycle strobe is raised. The strobe serves both as the valid flag and as the wake request for a sleeping consumer. The channel then re-arms for the next start edge.

The bit period and half-bit period are inputs. At 9600 baud with a 1 MHz timer clock they are 104 and 52 ticks.

Top module: `ccTimedRx`

## Requirements
- R1: After reset the channel is in capture mode (`inCapture` = 1), `byteReady` = 0 and `rxByte` = 0x00.
- R2: In capture mode, a high-to-low transition of the line, after a two-flop synchronizer, puts the channel into compare mode (`inCapture` = 0) within four clock cycles of the line falling.
- R3: The first sample is taken when the timer equals the captured value plus `bitPeriod` plus `halfPeriod`. Each later sample is taken `bitPeriod` ticks after the previous one. All timer arithmetic wraps modulo 2^16, and a match is an exact equality.
- R4: Bits arrive least significant first. Each sample shifts the register right and enters at bit 7, so the first data bit after the start bit lands in `rxByte[0]`.
- R5: When the eighth sample is taken, `rxByte` is loaded with the assembled byte and `byteReady` is high for exactly one cycle. In that same cycle the channel is back in capture mode.
- R6: While in compare mode, falling edges on the line (those inside the data bits) neither restart reception nor change the schedule.
- R7: The sample schedule follows the `bitPeriod` and `halfPeriod` inputs, including the 104/52 setting.
- R8: `rxByte` changes only in a cycle where `byteReady` is high. Between characters it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the timer advances on this clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| timerVal | input | 16 | Value of the shared free-running timer |
| bitPeriod | input | 16 | Timer ticks per bit |
| halfPeriod | input | 16 | Timer ticks per half bit |
| rxByte | output | 8 | Last received character |
| byteReady | output | 1 | One-cycle valid / wake strobe |
| inCapture | output | 1 | 1 while waiting for a start edge |

## Verification
The bench builds the block with its default 16-bit timer and 8 data bits. At run time it drives a bit period of 16 ticks with a half period of 8, so many characters fit in a short run. It starts the timer just below 0xFFFF, so the captured value, the compare target and the advancing sample points all wrap through zero early in the run. A final character at 104/52 reaches the 9600-baud setting. The data patterns 0x00, 0xFF, 0x01, 0x80, 0xA5 and 0x55 expose bit order, stuck bits and the falling edges inside a frame that must be ignored.

// File: rtl/ccRxPkg.sv
package ccRxPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic arm;     // load first compare target from timer
    logic step;    // take a sample and advance the target
    logic finish;  // last sample: publish the byte
  } rxCtl_t;
endpackage

// File: rtl/ccRxDatapath.sv
module ccRxDatapath
  import ccRxPkg::*;
#(
  parameter int TW = 16,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxLine,
  input  logic [TW-1:0] timerVal,
  input  logic [TW-1:0] bitPeriod,
  input  logic [TW-1:0] halfPeriod,
  input  rxCtl_t        ctl,
  output logic          fallEdge,
  output logic          cmpHit,
  output logic [DW-1:0] rxByte
);
  logic [SYNC_STAGES-1:0] syncReg;
  logic                   lineQ;
  logic                   lineDly;
  logic [TW-1:0]          cmpReg;
  logic [DW-1:0]          shiftReg;
  logic [DW-1:0]          nextShift;

  assign lineQ     = syncReg[SYNC_STAGES-1];
  assign fallEdge  = lineDly & ~lineQ;
  assign cmpHit    = (timerVal == cmpReg);
  assign nextShift = {lineQ, shiftReg[DW-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncReg <= '1;
      lineDly <= 1'b1;
    end else begin
      syncReg <= {syncReg[SYNC_STAGES-2:0], rxLine};
      lineDly <= lineQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpReg   <= '0;
      shiftReg <= '0;
      rxByte   <= '0;
    end else begin
      if (ctl.arm)       cmpReg <= timerVal + bitPeriod + halfPeriod;
      else if (ctl.step) cmpReg <= cmpReg + bitPeriod;
      if (ctl.step)      shiftReg <= nextShift;
      if (ctl.finish)    rxByte <= nextShift;
    end
  end

  // R3: first target sits one and a half bits after the captured time
  p_first_target_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.arm |=> (TW'(cmpReg - $past(timerVal)) == TW'($past(bitPeriod) + $past(halfPeriod))));
  // R3: each sample moves the target by exactly one bit
  p_target_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.arm) |=> (TW'(cmpReg - $past(cmpReg)) == $past(bitPeriod)));
  // R4: newest sample enters at the top bit
  p_msb_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> (shiftReg[DW-1] == $past(lineQ)));
endmodule

// File: rtl/ccRxCtrl.sv
module ccRxCtrl
  import ccRxPkg::*;
#(
  parameter int DW = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   fallEdge,
  input  logic   cmpHit,
  output rxCtl_t ctl,
  output logic   byteReady,
  output logic   inCapture
);
  localparam int CW = $clog2(DW + 1);

  logic          capMode;
  logic [CW-1:0] bitCnt;

  assign inCapture  = capMode;
  assign ctl.arm    = capMode & fallEdge;
  assign ctl.step   = ~capMode & cmpHit;
  assign ctl.finish = ctl.step & (bitCnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capMode   <= 1'b1;
      bitCnt    <= CW'(DW);
      byteReady <= 1'b0;
    end else begin
      byteReady <= ctl.finish;
      if (ctl.arm) begin
        capMode <= 1'b0;
        bitCnt  <= CW'(DW);
      end else if (ctl.step) begin
        if (ctl.finish) begin
          capMode <= 1'b1;
          bitCnt  <= CW'(DW);
        end else begin
          bitCnt <= bitCnt - CW'(1);
        end
      end
    end
  end

  // R2: a start edge seen while idle leaves capture mode
  p_start_leaves_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    (capMode && fallEdge) |=> !capMode);
  // R6: edges during compare mode do not touch the bit count
  p_edge_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!capMode && fallEdge && !cmpHit) |=> (!capMode && $stable(bitCnt)));
  // R5: strobe lasts one cycle and comes with capture mode
  p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |=> !byteReady);
  p_strobe_rearm_r5: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> capMode);
endmodule

// File: rtl/ccTimedRx.sv
module ccTimedRx
  import ccRxPkg::*;
#(
  parameter int TW = 16,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxLine,
  input  logic [TW-1:0] timerVal,
  input  logic [TW-1:0] bitPeriod,
  input  logic [TW-1:0] halfPeriod,
  output logic [DW-1:0] rxByte,
  output logic          byteReady,
  output logic          inCapture
);
  rxCtl_t ctl;
  logic   fallEdge;
  logic   cmpHit;

  ccRxDatapath #(.TW(TW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .timerVal(timerVal),
    .bitPeriod(bitPeriod), .halfPeriod(halfPeriod), .ctl(ctl),
    .fallEdge(fallEdge), .cmpHit(cmpHit), .rxByte(rxByte)
  );

  ccRxCtrl #(.DW(DW)) i_ctrl (
    .clk(clk), .rstN(rstN), .fallEdge(fallEdge), .cmpHit(cmpHit),
    .ctl(ctl), .byteReady(byteReady), .inCapture(inCapture)
  );

  // R8: the output byte only moves together with the strobe
  p_byte_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !byteReady |-> $stable(rxByte));
endmodule

// File: tb/test_ccTimedRx.sv
module test_ccTimedRx;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxLine = 1'b1;
  logic [15:0] timerVal = 16'hFF40;
  logic [15:0] bitPeriod = 16'd16;
  logic [15:0] halfPeriod = 16'd8;
  logic [7:0]  rxByte;
  logic        byteReady;
  logic        inCapture;

  int checks = 0;
  int fails = 0;
  logic [7:0] expQ[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) timerVal <= timerVal + 16'd1;

  ccTimedRx i_ccTimedRx (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .timerVal(timerVal),
    .bitPeriod(bitPeriod), .halfPeriod(halfPeriod),
    .rxByte(rxByte), .byteReady(byteReady), .inCapture(inCapture)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: push expectation, then shape the frame on the line
  task automatic sendByte(input logic [7:0] b);
    int bp;
    bp = int'(bitPeriod);
    expQ.push_back(b);
    rxLine = 1'b0;
    waitCycles(4);
    check(!inCapture, "R2 start edge enters compare mode", inCapture, 0);
    waitCycles(bp - 4);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      waitCycles(bp / 2);
      if (i == 4) check(!inCapture, "R6 inner edges ignored", inCapture, 0);
      waitCycles(bp - bp / 2);
    end
    rxLine = 1'b1;
    waitCycles(bp);
    check(inCapture, "R5 back in capture mode", inCapture, 1);
    waitCycles(5);
  endtask

  // monitor: pop and compare when the strobe shows up
  initial begin
    forever begin
      @(negedge clk);
      if (byteReady) begin
        logic [7:0] e;
        if (expQ.size() == 0) begin
          check(0, "R5 unexpected byte", rxByte, 0);
        end else begin
          e = expQ.pop_front();
          check(rxByte == e, "R3 R4 received byte", rxByte, e);
        end
        check(inCapture, "R5 capture with strobe", inCapture, 1);
        @(negedge clk);
        check(!byteReady, "R5 strobe one cycle", byteReady, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);
    check(inCapture, "R1 reset capture mode", inCapture, 1);
    check(!byteReady, "R1 reset strobe low", byteReady, 0);
    check(rxByte == 8'h00, "R1 reset byte", rxByte, 0);
    waitCycles(10);
    // R3 wrap: timer passes 0xFFFF during the first frames
    sendByte(8'hA5);
    sendByte(8'h00);
    sendByte(8'hFF);
    sendByte(8'h01);   // R4 lsb first
    sendByte(8'h80);
    sendByte(8'h55);   // R6 many falling edges inside data
    bitPeriod = 16'd104;
    halfPeriod = 16'd52;
    waitCycles(20);
    sendByte(8'h3C);   // R7 9600-baud setting
    waitCycles(50);
    held = rxByte;
    check(held == 8'h3C, "R7 byte at 104/52", held, 8'h3C);
    waitCycles(300);
    check(rxByte == held, "R8 byte holds while idle", rxByte, held);
    check(expQ.size() == 0, "R5 all bytes delivered", expQ.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule